// File: doc/BRIEF.md
# Dual-Channel Sampled Output Multiplexer

This block is the digital output path of a matched pair of 8-bit converter channels, called I and Q. On every rising clock edge it takes one I code and one Q code together. Both codes travel through one shared fixed-latency delay line into an output register for each channel. The two registered words are then merged onto a single 8-bit bus. A level-sensitive channel-select input picks the word, and it acts at once, without waiting for a clock edge. A downstream receiver can therefore de-interleave the channels by tying the select line to the clock, or it can hold the select line steady to read one channel only.

A bus-release input takes the bus off the wire. The release is modelled as a drive-enable output next to the data, so that no internal tri-state is needed. A sleep input freezes the delay line and the output registers. After sleep is released, a valid flag stays low until the delay line again holds only fresh samples. Codes are plain unsigned words in offset binary, with bit 7 as the most significant bit.

Top module: `iq_bus_mux`

## Requirements
- R1: A synchronous active-high reset clears both channel output registers and every stage of the delay line to 8'h00, and clears the valid flag. The first bus word after reset is therefore 8'h00.
- R2: An I/Q pair sampled at rising edge k appears in the channel output registers right after edge k+3, and not earlier. Both codes of the pair travel together.
- R3: With sleep low, a new pair is accepted on every rising edge. Consecutive samples leave on consecutive cycles, with no gaps and no repeats.
- R4: With the bus enabled, channel select = 1 puts the I output register on the bus and channel select = 0 puts the Q output register on the bus. A change of select alters the bus within the same cycle, without a clock edge.
- R5: With bus release = 1, the drive-enable output is 0 and the data output is 8'h00. With bus release = 0, the drive-enable output is 1 and the selected word is shown.
- R6: While sleep = 1, the delay line and the output registers keep their contents. Input codes presented during sleep are never captured and never reach the bus.
- R7: The valid flag is 1 only after 4 consecutive rising edges with sleep = 0 since the last reset or sleep edge. It falls right after any edge at which sleep is 1.
- R8: Words pass unchanged as 8-bit offset binary, with bit 7 as the MSB and bit 0 as the LSB. There is no reordering or inversion of bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; the rising edge captures both channels |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | 1 freezes conversion (power-down), 0 runs normally |
| chan_sel_i | input | 1 | 1 shows the I word, 0 shows the Q word; acts combinationally |
| bus_release_i | input | 1 | 1 releases the bus (no drive), 0 drives it |
| i_code_i | input | 8 | I channel code sampled at the rising edge |
| q_code_i | input | 8 | Q channel code sampled at the rising edge |
| bus_o | output | 8 | Shared output word, 8'h00 when released |
| bus_drive_o | output | 1 | Drive enable for an external bus buffer |
| valid_o | output | 1 | Delay line holds only fresh samples |

## Verification
Suppose a stage of the delay line is dropped, duplicated or enabled at the wrong time. Each output word would then carry a sample taken one cycle too early or too late. A reference queue in the bench shows that mismatch on the first bus word compared after the marker sample is due, which is four edges after it was driven. A faulty select path or a faulty release path shows up inside the same cycle, because the bus is compared again only a moment after select is toggled between edges. A fill counter that is wrong, or a sleep gate that leaks, shows up within one edge. It appears either as a valid flag that rises on the wrong edge or as a bus word that changes while sleep is held.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

    localparam int CODE_W   = 8;
    localparam int PIPE_LAT = 3;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t i_word;
        code_t q_word;
    } iq_pair_t;

    typedef enum logic {
        CH_Q = 1'b0,
        CH_I = 1'b1
    } chan_e;

    function automatic iq_pair_t pack_pair(input code_t i_w, input code_t q_w);
        iq_pair_t p;
        p.i_word = i_w;
        p.q_word = q_w;
        return p;
    endfunction

    function automatic code_t pick_word(input iq_pair_t p, input chan_e ch);
        return (ch == CH_I) ? p.i_word : p.q_word;
    endfunction

endpackage

// File: rtl/iqm_pipe.sv
module iqm_pipe
    import iqm_pkg::*;
#(
    parameter int STAGES = PIPE_LAT + 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     advance,
    input  iq_pair_t din,
    output iq_pair_t dout
);

    iq_pair_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q[0] <= '0;
        end else if (advance) begin
            stage_q[0] <= din;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= '0;
            end else if (advance) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

    // R6: a frozen cycle leaves the output register unchanged
    assert_hold_when_frozen_R6: assert property (
        @(posedge clk) disable iff (rst)
        !advance |=> $stable(dout)
    );

    // R1: the output register is zero right after a reset edge
    assert_clear_after_reset_R1: assert property (
        @(posedge clk) $past(rst) |-> (dout == '0)
    );

endmodule

// File: rtl/iqm_fill_tracker.sv
module iqm_fill_tracker #(
    parameter int FULL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output logic full_o
);

    localparam int CNT_W = $clog2(FULL + 1);

    logic [CNT_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst || !advance) begin
            fill_q <= '0;
        end else if (fill_q != CNT_W'(FULL)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign full_o = (fill_q == CNT_W'(FULL));

    // R7: a sleeping edge always drops the flag
    assert_valid_drops_R7: assert property (
        @(posedge clk) disable iff (rst)
        !advance |=> !full_o
    );

endmodule

// File: rtl/iqm_out_mux.sv
module iqm_out_mux
    import iqm_pkg::*;
(
    input  iq_pair_t held,
    input  logic     sel_i_chan,
    input  logic     release_bus,
    output code_t    word_o,
    output logic     drive_o
);

    chan_e ch;

    always_comb begin
        ch      = sel_i_chan ? CH_I : CH_Q;
        drive_o = !release_bus;
        word_o  = release_bus ? '0 : pick_word(held, ch);
    end

endmodule

// File: rtl/iq_bus_mux.sv
module iq_bus_mux
    import iqm_pkg::*;
#(
    parameter int LATENCY = PIPE_LAT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sleep_i,
    input  logic        chan_sel_i,
    input  logic        bus_release_i,
    input  logic [7:0]  i_code_i,
    input  logic [7:0]  q_code_i,
    output logic [7:0]  bus_o,
    output logic        bus_drive_o,
    output logic        valid_o
);

    localparam int STAGES = LATENCY + 1;

    logic     run;
    iq_pair_t in_pair;
    iq_pair_t out_pair;

    assign run     = !sleep_i;
    assign in_pair = pack_pair(i_code_i, q_code_i);

    iqm_pipe #(.STAGES(STAGES)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .advance (run),
        .din     (in_pair),
        .dout    (out_pair)
    );

    iqm_fill_tracker #(.FULL(STAGES)) u_fill (
        .clk     (clk),
        .rst     (rst),
        .advance (run),
        .full_o  (valid_o)
    );

    iqm_out_mux u_mux (
        .held        (out_pair),
        .sel_i_chan  (chan_sel_i),
        .release_bus (bus_release_i),
        .word_o      (bus_o),
        .drive_o     (bus_drive_o)
    );

    // R2: once filled, each output register holds the sample taken LATENCY edges earlier
    assert_i_latency_R2: assert property (
        @(posedge clk) disable iff (rst)
        valid_o |-> (out_pair.i_word == $past(i_code_i, STAGES))
    );

    assert_q_latency_R2: assert property (
        @(posedge clk) disable iff (rst)
        valid_o |-> (out_pair.q_word == $past(q_code_i, STAGES))
    );

    // R4: the bus follows the chosen channel register
    assert_select_i_R4: assert property (
        @(posedge clk) disable iff (rst)
        (!bus_release_i && chan_sel_i) |-> (bus_o == out_pair.i_word)
    );

    assert_select_q_R4: assert property (
        @(posedge clk) disable iff (rst)
        (!bus_release_i && !chan_sel_i) |-> (bus_o == out_pair.q_word)
    );

    // R5: a released bus neither drives nor carries data
    assert_release_R5: assert property (
        @(posedge clk) disable iff (rst)
        bus_release_i |-> (!bus_drive_o && bus_o == 8'h00)
    );

endmodule

// File: tb/iq_bus_mux_tb.sv
module iq_bus_mux_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep = 1'b0;
    logic       sel = 1'b1;
    logic       rel = 1'b0;
    logic [7:0] i_in = 8'h00;
    logic [7:0] q_in = 8'h00;
    logic [7:0] bus;
    logic       drive;
    logic       valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] mi[$];
    logic [7:0] mq[$];
    int         mcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_bus_mux u_dut (
        .clk           (clk),
        .rst           (rst),
        .sleep_i       (sleep),
        .chan_sel_i    (sel),
        .bus_release_i (rel),
        .i_code_i      (i_in),
        .q_code_i      (q_in),
        .bus_o         (bus),
        .bus_drive_o   (drive),
        .valid_o       (valid)
    );

    // Behavioural reference: a queue of the last DEPTH accepted pairs
    always @(posedge clk) begin
        if (rst) begin
            mi.delete();
            mq.delete();
            for (int k = 0; k < DEPTH; k++) begin
                mi.push_back(8'h00);
                mq.push_back(8'h00);
            end
            mcnt = 0;
        end else if (!sleep) begin
            mi.push_back(i_in);
            mq.push_back(q_in);
            void'(mi.pop_front());
            void'(mq.pop_front());
            if (mcnt < DEPTH) mcnt = mcnt + 1;
        end else begin
            mcnt = 0;
        end
    end

    function automatic logic [7:0] exp_bus();
        if (rel) return 8'h00;
        return sel ? mi[0] : mq[0];
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        chk(tag, "bus", int'(bus), int'(exp_bus()));
        chk("R5", "drive", int'(drive), int'(!rel));
        chk("R7", "valid", int'(valid), int'(mcnt == DEPTH));
    endtask

    task automatic cyc(input string tag, input logic [7:0] iv, input logic [7:0] qv);
        @(negedge clk);
        cmp_all(tag);
        i_in = iv;
        q_in = qv;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        for (int k = 0; k < DEPTH; k++) begin
            mi.push_back(8'h00);
            mq.push_back(8'h00);
        end
        i_in = 8'h5A;
        q_in = 8'hC3;
        repeat (3) @(negedge clk);
        // R1: reset clears output registers and valid
        chk("R1", "bus after reset", int'(bus), 0);
        chk("R1", "valid after reset", int'(valid), 0);
        rst = 1'b0;

        // R2: single marker appears exactly after the fourth edge
        cyc("R2", 8'hA5, 8'h3C);
        for (int k = 0; k < 6; k++) cyc("R2", 8'h00, 8'h00);

        // R3: continuous stream on both channels, both select values
        for (int k = 0; k < 16; k++) begin
            if (k == 8) sel = 1'b0;
            cyc("R3", 8'(k * 17 + 3), 8'(8'hF0 - k * 11));
        end

        // R4: select acts between clock edges
        @(negedge clk);
        sel = 1'b1;
        #1;
        chk("R4", "bus sel=1 mid-cycle", int'(bus), int'(mi[0]));
        sel = 1'b0;
        #1;
        chk("R4", "bus sel=0 mid-cycle", int'(bus), int'(mq[0]));
        sel = 1'b1;
        #1;
        chk("R4", "bus sel=1 again", int'(bus), int'(mi[0]));

        // R5: bus release while streaming
        rel = 1'b1;
        for (int k = 0; k < 4; k++) cyc("R5", 8'(8'h40 + k), 8'(8'h80 + k));
        rel = 1'b0;
        for (int k = 0; k < 3; k++) cyc("R5", 8'(8'h50 + k), 8'(8'h90 + k));

        // R6 / R7: sleep freezes the path and drops valid
        @(negedge clk);
        cmp_all("R6");
        held  = bus;
        sleep = 1'b1;
        for (int k = 0; k < 5; k++) begin
            i_in = 8'(8'hE0 + k);
            q_in = 8'(8'h10 + k);
            @(negedge clk);
            chk("R6", "bus frozen in sleep", int'(bus), int'(held));
            chk("R7", "valid in sleep", int'(valid), 0);
        end
        sleep = 1'b0;
        i_in  = 8'h21;
        q_in  = 8'h12;
        for (int k = 1; k <= DEPTH + 2; k++) begin
            @(negedge clk);
            chk("R7", "valid refill", int'(valid), int'(k >= DEPTH));
            cmp_all("R6");
            i_in = 8'(8'h22 + k);
            q_in = 8'(8'h13 + k);
        end

        // R8: bit order kept, MSB on bit 7, LSB on bit 0
        cyc("R8", 8'h80, 8'h01);
        for (int k = 0; k < 3; k++) cyc("R8", 8'h00, 8'h00);
        @(negedge clk);
        sel = 1'b1;
        #1;
        chk("R8", "I word bit7", int'(bus), 8'h80);
        sel = 1'b0;
        #1;
        chk("R8", "Q word bit0", int'(bus), 8'h01);

        // R1: reset in the middle of a stream
        for (int k = 0; k < 3; k++) cyc("R3", 8'(8'h77 + k), 8'(8'h66 + k));
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "bus after mid reset", int'(bus), 0);
        chk("R1", "valid after mid reset", int'(valid), 0);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) cyc("R2", 8'(8'h31 + k), 8'(8'h41 + k));

        finish_run();
    end

endmodule